// File: doc/BRIEF.md
# Double-Data-Rate Four-Word Burst SRAM Model

A synthesizable model of a pipelined synchronous SRAM whose data port moves two words per input clock period. Each access is a fixed burst of four 36-bit words. A controller starts an operation with an active-low load strobe and a read/write select on a rising edge of the input clock `k`. It presents write data on the rising edges of both `k_n` and `k`, and receives read data launched on the rising edges of the output clock pair `c_n` and `c`. Read data and write data share one bidirectional bus. A pair of echo clocks, `cq` and `cq_n`, travels with the read data so the receiver can capture it.

The two low address bits seed a 2-bit burst position that counts up modulo four. A burst therefore wraps inside its aligned group of four words. The upper bits select the group. Four active-low byte-write selects mask 9-bit lanes of every written word. Because a burst occupies two `k` periods, a new operation can start at most on every other `k` rising edge. A load on the edge right after an accepted one is ignored. Setting parameter `USE_C` to 0 launches read data from `k`/`k_n` instead of `c`/`c_n`. The array depth comes from the address width parameter.

Top module: `ddr_burst_sram`

## Requirements
- R1: While `rst` is high on `k` edges, no operation is accepted and the data bus `dq` is not driven.
- R2: A write accepted on `k` edge n (`ld_n`=0, `rw`=0) captures words 0..3 from `dq` on the `k_n` rising edge at n+0.5, the `k` edge n+1, the `k_n` edge n+1.5 and the `k` edge n+2. Word i is stored at group `addr[AW-1:2]`, position (`addr[1:0]`+i) mod 4.
- R3: A `k` edge that directly follows an accepted edge ignores `ld_n`, `rw` and `addr`, so it starts neither a read nor a write.
- R4: A read accepted on `k` edge n drives word 0 on `dq` after the `c_n` rising edge at n+1.5. Words 1, 2 and 3 follow after the `c` edge n+2, the `c_n` edge n+2.5 and the `c` edge n+3. Word i is taken from position (`addr[1:0]`+i) mod 4 of the addressed group.
- R5: Bit l of `bw_n` sampled with a write word (0 = write) enables lane l, bits 9l+8..9l of that word. A lane whose bit is 1 keeps its stored value.
- R6: A `k` edge with `ld_n`=1 starts nothing. `dq` is released after the first `c_n` rising edge that follows the last word of a read burst unless another burst continues.
- R7: Reads accepted on `k` edges n and n+2 produce eight back-to-back words with no gap.
- R8: After reset, `cq` is 1 after each `c` rising edge and 0 after each `c_n` rising edge. `cq_n` is always its complement.
- R9: A read accepted two `k` edges after a write to the same group returns the newly written data.
- R10: `rw`=1 selects a read and `rw`=0 selects a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| k | input | 1 | Input clock; rising edge samples control, address and odd write words |
| k_n | input | 1 | Complement input clock; rising edge samples even write words |
| c | input | 1 | Output clock; rising edge launches odd read words |
| c_n | input | 1 | Complement output clock; rising edge launches even read words |
| rst | input | 1 | Synchronous active-high reset |
| ld_n | input | 1 | Active-low operation start strobe |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | AW | Word address; two LSBs seed the burst position |
| bw_n | input | 4 | Active-low byte-lane write selects, one per 9-bit lane |
| dq | inout | 36 | Shared read/write data bus |
| cq | output | 1 | Echo clock in phase with `c` |
| cq_n | output | 1 | Complement echo clock |

## Verification
On every `k` edge, the assertions check four things. Accepted operations are never on adjacent edges. A write or read burst always passes through both of its two clock periods. The write address holds steady across its capture window. A write commit and an array read never fall on the same edge. Only the bench scenarios can show the data itself: the wrap order of burst positions, lane masking, the 1.5-cycle read latency, bus release, gapless back-to-back reads, and the fact that ignored edges leave memory untouched. The bench shows these by comparing the bus on every half cycle against a behavioural model.

// File: rtl/ddrb_pkg.sv
package ddrb_pkg;
  localparam int WORD_W    = 36;
  localparam int LANE_W    = 9;
  localparam int LANES     = WORD_W / LANE_W;
  localparam int BEATS     = 4;
  localparam int GRP_W     = WORD_W * BEATS;
  localparam int GRP_LANES = LANES * BEATS;

  function automatic logic [1:0] burst_pos(input logic [1:0] seed, input logic [1:0] idx);
    return seed + idx;
  endfunction
endpackage

// File: rtl/ddrb_ctrl.sv
module ddrb_ctrl #(
  parameter int AW = 10
) (
  input  logic          k,
  input  logic          rst,
  input  logic          ld_n,
  input  logic          rw,
  input  logic [AW-1:0] addr,
  output logic          wr_act,
  output logic          wr_slot,
  output logic [AW-1:2] wr_hi,
  output logic [1:0]    wr_lo,
  output logic          commit,
  output logic          rd_pend,
  output logic [AW-1:2] rd_hi,
  output logic          rd_act,
  output logic          rd_slot,
  output logic [1:0]    rd_lo
);
  logic       hold;
  logic       accept;
  logic [1:0] rq_lo;

  assign accept = !ld_n && !hold;
  assign commit = wr_act && wr_slot;

  always_ff @(posedge k) begin
    if (rst) begin
      hold    <= 1'b0;
      wr_act  <= 1'b0;
      wr_slot <= 1'b0;
      rd_pend <= 1'b0;
      rd_act  <= 1'b0;
      rd_slot <= 1'b0;
    end else begin
      hold    <= accept;
      rd_pend <= accept && rw;
      if (wr_act && !wr_slot) begin
        wr_slot <= 1'b1;
      end else begin
        wr_act  <= accept && !rw;
        wr_slot <= 1'b0;
      end
      if (rd_pend) begin
        rd_act  <= 1'b1;
        rd_slot <= 1'b0;
      end else if (rd_act && !rd_slot) begin
        rd_slot <= 1'b1;
      end else begin
        rd_act  <= 1'b0;
        rd_slot <= 1'b0;
      end
    end
  end

  always_ff @(posedge k) begin
    if (accept && rw) begin
      rd_hi <= addr[AW-1:2];
      rq_lo <= addr[1:0];
    end
    if (accept && !rw) begin
      wr_hi <= addr[AW-1:2];
      wr_lo <= addr[1:0];
    end
    if (rd_pend) rd_lo <= rq_lo;
  end

  AST_ACCEPT_SPACING: assert property (@(posedge k) disable iff (rst)
    accept |=> !accept); // R3
  AST_WR_TWO_PERIODS: assert property (@(posedge k) disable iff (rst)
    (wr_act && !wr_slot) |=> (wr_act && wr_slot)); // R2
  AST_WR_ADDR_HELD: assert property (@(posedge k) disable iff (rst)
    (wr_act && !wr_slot) |=> ($stable(wr_hi) && $stable(wr_lo))); // R2
  AST_RD_BURST_START: assert property (@(posedge k) disable iff (rst)
    rd_pend |=> (rd_act && !rd_slot)); // R4
  AST_NO_PORT_CLASH: assert property (@(posedge k) disable iff (rst)
    !(commit && rd_pend)); // R9
endmodule

// File: rtl/ddrb_wcap.sv
module ddrb_wcap
  import ddrb_pkg::*;
(
  input  logic                 k,
  input  logic                 k_n,
  input  logic [WORD_W-1:0]    din,
  input  logic [LANES-1:0]     bw_n,
  input  logic                 wr_act,
  input  logic                 wr_slot,
  input  logic [1:0]           wr_lo,
  output logic [GRP_W-1:0]     grp,
  output logic [GRP_LANES-1:0] lane_we
);
  logic [WORD_W-1:0] w0, w1, w2;
  logic [LANES-1:0]  m0, m1, m2;
  logic [WORD_W-1:0] wv [BEATS];
  logic [LANES-1:0]  mv [BEATS];

  always_ff @(posedge k_n) begin
    if (wr_act && !wr_slot) begin
      w0 <= din;
      m0 <= bw_n;
    end
    if (wr_act && wr_slot) begin
      w2 <= din;
      m2 <= bw_n;
    end
  end

  always_ff @(posedge k) begin
    if (wr_act && !wr_slot) begin
      w1 <= din;
      m1 <= bw_n;
    end
  end

  always_comb begin
    wv[0] = w0; wv[1] = w1; wv[2] = w2; wv[3] = din;
    mv[0] = m0; mv[1] = m1; mv[2] = m2; mv[3] = bw_n;
    grp     = '0;
    lane_we = '0;
    for (int i = 0; i < BEATS; i++) begin
      logic [1:0] pos;
      pos = burst_pos(wr_lo, 2'(i));
      grp[int'(pos)*WORD_W +: WORD_W] = wv[i];
      for (int l = 0; l < LANES; l++)
        lane_we[int'(pos)*LANES + l] = !mv[i][l];
    end
  end
endmodule

// File: rtl/ddrb_array.sv
module ddrb_array
  import ddrb_pkg::*;
#(
  parameter int GAW = 8
) (
  input  logic                 k,
  input  logic                 we,
  input  logic [GAW-1:0]       waddr,
  input  logic [GRP_W-1:0]     wdata,
  input  logic [GRP_LANES-1:0] lane_we,
  input  logic                 re,
  input  logic [GAW-1:0]       raddr,
  output logic [GRP_W-1:0]     rdata
);
  localparam int DEPTH = 1 << GAW;
  logic [GRP_W-1:0] mem [DEPTH];

  always_ff @(posedge k) begin
    if (we) begin
      for (int l = 0; l < GRP_LANES; l++)
        if (lane_we[l]) mem[waddr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
    end
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ddrb_oddr.sv
module ddrb_oddr #(
  parameter int W = 1
) (
  input  logic         clk_p,
  input  logic         clk_n,
  input  logic         rst,
  input  logic [W-1:0] d_p,
  input  logic [W-1:0] d_n,
  output logic [W-1:0] q
);
  logic [W-1:0] rp, rn;

  always_ff @(posedge clk_p) begin
    if (rst) rp <= '0;
    else     rp <= d_p ^ rn;
  end

  always_ff @(posedge clk_n) begin
    if (rst) rn <= '0;
    else     rn <= d_n ^ rp;
  end

  assign q = rp ^ rn;
endmodule

// File: rtl/ddr_burst_sram.sv
module ddr_burst_sram
  import ddrb_pkg::*;
#(
  parameter int AW    = 10,
  parameter bit USE_C = 1'b1
) (
  input  logic          k,
  input  logic          k_n,
  input  logic          c,
  input  logic          c_n,
  input  logic          rst,
  input  logic          ld_n,
  input  logic          rw,
  input  logic [AW-1:0] addr,
  input  logic [3:0]    bw_n,
  inout  wire  [35:0]   dq,
  output logic          cq,
  output logic          cq_n
);
  localparam int GAW = AW - 2;

  logic                 wr_act, wr_slot, commit, rd_pend, rd_act, rd_slot;
  logic [AW-1:2]        wr_hi, rd_hi;
  logic [1:0]           wr_lo, rd_lo;
  logic [GRP_W-1:0]     wgrp, rgrp;
  logic [GRP_LANES-1:0] lane_we;
  logic [WORD_W-1:0]    d_p, d_n, q_out;
  logic                 oe, echo;
  logic [1:0]           pos_p, pos_n;

  ddrb_ctrl #(.AW(AW)) u_ctrl (
    .k(k), .rst(rst), .ld_n(ld_n), .rw(rw), .addr(addr),
    .wr_act(wr_act), .wr_slot(wr_slot), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .commit(commit), .rd_pend(rd_pend), .rd_hi(rd_hi),
    .rd_act(rd_act), .rd_slot(rd_slot), .rd_lo(rd_lo)
  );

  ddrb_wcap u_wcap (
    .k(k), .k_n(k_n), .din(dq), .bw_n(bw_n),
    .wr_act(wr_act), .wr_slot(wr_slot), .wr_lo(wr_lo),
    .grp(wgrp), .lane_we(lane_we)
  );

  ddrb_array #(.GAW(GAW)) u_array (
    .k(k), .we(commit), .waddr(wr_hi), .wdata(wgrp), .lane_we(lane_we),
    .re(rd_pend), .raddr(rd_hi), .rdata(rgrp)
  );

  always_comb begin
    pos_p = burst_pos(rd_lo, {rd_slot, 1'b1});
    pos_n = burst_pos(rd_lo, {rd_slot, 1'b0});
    d_p   = rgrp[int'(pos_p)*WORD_W +: WORD_W];
    d_n   = rgrp[int'(pos_n)*WORD_W +: WORD_W];
  end

  generate
    if (USE_C) begin : g_out_c
      ddrb_oddr #(.W(WORD_W)) u_data (.clk_p(c), .clk_n(c_n), .rst(rst), .d_p(d_p), .d_n(d_n), .q(q_out));
      ddrb_oddr #(.W(1)) u_oe (.clk_p(c), .clk_n(c_n), .rst(rst), .d_p(rd_act), .d_n(rd_act), .q(oe));
      ddrb_oddr #(.W(1)) u_echo (.clk_p(c), .clk_n(c_n), .rst(rst), .d_p(1'b1), .d_n(1'b0), .q(echo));
    end else begin : g_out_k
      ddrb_oddr #(.W(WORD_W)) u_data (.clk_p(k), .clk_n(k_n), .rst(rst), .d_p(d_p), .d_n(d_n), .q(q_out));
      ddrb_oddr #(.W(1)) u_oe (.clk_p(k), .clk_n(k_n), .rst(rst), .d_p(rd_act), .d_n(rd_act), .q(oe));
      ddrb_oddr #(.W(1)) u_echo (.clk_p(k), .clk_n(k_n), .rst(rst), .d_p(1'b1), .d_n(1'b0), .q(echo));
    end
  endgenerate

  assign dq   = oe ? q_out : 'z;
  assign cq   = echo;
  assign cq_n = !echo;
endmodule

// File: tb/sim_ddr_burst_sram.sv
module sim_ddr_burst_sram;
  localparam int EMAX = 92;

  logic        k = 1'b0, k_n = 1'b1, c = 1'b0, c_n = 1'b1;
  logic        rst = 1'b1, ld_n = 1'b1, rw = 1'b0;
  logic [9:0]  addr = '0;
  logic [3:0]  bw_n = 4'hF;
  logic        tb_oe = 1'b0;
  logic [35:0] tb_d = '0;
  tri1  [35:0] dq;
  logic        cq, cq_n;

  assign dq = tb_oe ? tb_d : 36'bz;

  ddr_burst_sram u0 (
    .k(k), .k_n(k_n), .c(c), .c_n(c_n), .rst(rst), .ld_n(ld_n), .rw(rw),
    .addr(addr), .bw_n(bw_n), .dq(dq), .cq(cq), .cq_n(cq_n)
  );

  logic        ldn_t [EMAX];
  logic        rw_t  [EMAX];
  logic [9:0]  a_t   [EMAX];
  logic        drv_e [EMAX];
  logic [35:0] drv_v [EMAX];
  logic [3:0]  bw_t  [EMAX];
  int          kind  [EMAX];
  logic [35:0] expv  [EMAX];
  string       tg    [EMAX];
  logic [35:0] mm    [1024];

  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  function automatic logic [35:0] pat(input int s, input int i);
    return 36'(s) * 36'h1_0204_0811 + 36'(i) * 36'h7_1000_0003;
  endfunction

  task automatic chk(input bit ok, input string req, input int e, input logic [35:0] act, input logic [35:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s at half-edge %0d: actual=%h expected=%h", req, e, act, exp);
    end
  endtask

  task automatic plan_write(input int n, input logic [9:0] a, input int s, input logic [15:0] m);
    ldn_t[2*n] = 1'b0; rw_t[2*n] = 1'b0; a_t[2*n] = a;
    for (int i = 0; i < 4; i++) begin
      logic [9:0] p;
      drv_e[2*n+1+i] = 1'b1;
      drv_v[2*n+1+i] = pat(s, i);
      bw_t[2*n+1+i]  = m[4*i +: 4];
      kind[2*n+1+i]  = 2;
      p = {a[9:2], 2'(a[1:0] + 2'(i))};
      for (int l = 0; l < 4; l++)
        if (!m[4*i+l]) mm[p][9*l +: 9] = pat(s, i) >> (9*l);
    end
  endtask

  task automatic plan_read(input int n, input logic [9:0] a, input string req);
    ldn_t[2*n] = 1'b0; rw_t[2*n] = 1'b1; a_t[2*n] = a;
    for (int j = 0; j < 4; j++) begin
      kind[2*n+3+j] = 1;
      expv[2*n+3+j] = mm[{a[9:2], 2'(a[1:0] + 2'(j))}];
      tg[2*n+3+j]   = req;
    end
  endtask

  initial begin
    for (int e = 0; e < EMAX; e++) begin
      ldn_t[e] = 1'b1; rw_t[e] = 1'b0; a_t[e] = '0;
      drv_e[e] = 1'b0; drv_v[e] = '0; bw_t[e] = 4'hF;
      kind[e] = 0; expv[e] = '1; tg[e] = (e < 10) ? "R1" : "R6";
    end
    // R2/R10: full writes, second one wraps from position 2
    plan_write(6, 10'h010, 1, 16'h0000);
    plan_write(8, 10'h016, 2, 16'h0000);
    plan_read(10, 10'h010, "R2");
    plan_read(12, 10'h015, "R7");            // R4 wrap order, contiguous with previous (R7)
    // R3: write on hold edge n=17 must be ignored
    plan_write(16, 10'h020, 3, 16'h0000);
    ldn_t[34] = 1'b0; rw_t[34] = 1'b0; a_t[34] = 10'h010;
    drv_e[37] = 1'b1; drv_v[37] = 36'h0_DEAD_BEEF; kind[37] = 2;
    drv_e[38] = 1'b1; drv_v[38] = 36'h0_BADC_0FFE; kind[38] = 2;
    // R6: idle edge with ld_n high and write-looking controls
    rw_t[36] = 1'b0; a_t[36] = 10'h010;
    // R5: masked write, start position 3
    plan_write(20, 10'h013, 4, {4'b0000, 4'b1111, 4'b0101, 4'b1110});
    plan_read(22, 10'h010, "R9");            // also R5 lane result
    plan_read(24, 10'h020, "R3");
    // R3: read on hold edge n=25 must be ignored
    ldn_t[50] = 1'b0; rw_t[50] = 1'b1; a_t[50] = 10'h014;
    plan_write(28, 10'h031, 5, 16'h0000);
    plan_read(30, 10'h030, "R10");
    plan_read(32, 10'h012, "R4");
  end

  initial begin
    for (int e = 0; e < EMAX - 1; e++) begin
      #5;
      if (e % 2 == 0) begin k = 1'b1; k_n = 1'b0; c = 1'b1; c_n = 1'b0; end
      else            begin k = 1'b0; k_n = 1'b1; c = 1'b0; c_n = 1'b1; end
      #5;
      if (e >= 4) begin
        if (kind[e] == 1)
          chk(dq === expv[e], tg[e], e, dq, expv[e]);
        else if (kind[e] == 0)
          chk(dq === 36'hF_FFFF_FFFF, tg[e], e, dq, 36'hF_FFFF_FFFF);
      end
      if (e >= 12) begin
        chk((cq === ((e % 2) == 0)) && (cq_n === ((e % 2) != 0)), "R8", e,
            36'({cq, cq_n}), 36'({((e % 2) == 0), ((e % 2) != 0)}));
      end
      rst = (e + 1 < 10);
      if ((e + 1) % 2 == 0) begin
        ld_n = ldn_t[e+1]; rw = rw_t[e+1]; addr = a_t[e+1];
      end
      tb_oe = drv_e[e+1];
      tb_d  = drv_v[e+1];
      bw_n  = bw_t[e+1];
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule